// File: doc/BRIEF.md
# Privileged Trap Entry Controller

This block takes a processor into its trap handler. In the cycle in which a trap request is raised, it decides whether the trap belongs to the supervisor level or to the machine level. It then updates that level's saved-status fields, cause, exception-pc and trap-value registers and the privilege register. It also produces the handler address that the fetch unit must jump to.

The caller supplies, for each request:
- whether the request is an interrupt or an exception;
- its cause code;
- the faulting address;
- the current pc and privilege;
- the two delegation masks, one for interrupts and one for exceptions;
- the machine and supervisor trap-vector registers.

The controller holds the interrupt-enable bits, the saved previous-enable and previous-privilege fields and both levels' trap registers. It exposes all of them as outputs.

Privilege encoding is 0 = user, 1 = supervisor, 2 = reserved, 3 = machine. A request whose code is 8 and whose interrupt flag is low is an environment call. It is renumbered according to the privilege it came from.

Top module: `trap_entry_ctrl`

## Requirements
- R1: While reset is high and after it, privilege is machine (3) and every cause, epc and tval register is zero. Both saved-enable bits are 0, the saved machine privilege is 0 and the saved supervisor privilege is 0. The machine and supervisor enable bits take the values of parameters MIE_RST and SIE_RST (default 1).
- R2: A trap goes to supervisor level only if all three hold: the current privilege is 0 or 1, the (renumbered) code is below XLEN, and bit `code` of the selected mask is 1. The mask is the interrupt mask for interrupts and the exception mask otherwise. Any other trap goes to machine level.
- R3: Supervisor entry copies the supervisor enable into the supervisor saved-enable, clears the supervisor enable, and sets the saved supervisor privilege to 1 if the trap came from privilege 1, else 0.
- R4: Machine entry copies the machine enable into the machine saved-enable, clears the machine enable, and stores the current 2-bit privilege in the saved machine privilege.
- R5: The chosen level's cause register gets the interrupt flag in bit XLEN-1 and the code in its low bits, zeros elsewhere. Its epc register gets the current pc.
- R6: The chosen level's tval register gets the faulting address only for exceptions with code 0, 1, 4, 5, 6, 7, 12, 13 or 15. For every other case it gets zero.
- R7: An exception with code 8 is renumbered to 8 from privilege 0, 9 from privilege 1 and 11 from privilege 2 or 3. The renumbered code is used both for routing and for the cause register. An interrupt with code 8 is not renumbered.
- R8: `redirect_pc` equals the chosen level's vector with its two low bits cleared. When the request is an interrupt and the vector's low two bits are 01, 4 times the code is added. Modes 00, 10 and 11 never add an offset.
- R9: After the entry edge, privilege is 1 for a supervisor entry and 3 for a machine entry. The other level's cause, epc, tval, enable and saved fields are unchanged.
- R10: In a cycle with no trap request, no register changes, whatever the other inputs do.
- R11: All updates from a request land on the clock edge that ends the request cycle. Requests on consecutive cycles each take full effect, the second one seeing the state left by the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Take a trap this cycle |
| trap_is_irq | input | 1 | 1 = interrupt, 0 = exception |
| trap_code | input | CODE_W | Raw cause code |
| fault_addr | input | XLEN | Faulting address for tval |
| cur_pc | input | XLEN | pc of the trapping instruction |
| cur_priv | input | 2 | Privilege at the time of the trap |
| exc_deleg | input | XLEN | Exception delegation mask |
| irq_deleg | input | XLEN | Interrupt delegation mask |
| m_tvec | input | XLEN | Machine trap vector (low 2 bits = mode) |
| s_tvec | input | XLEN | Supervisor trap vector (low 2 bits = mode) |
| priv_o | output | 2 | Privilege after the last entry |
| redirect_pc | output | XLEN | Handler address, valid while trap_req is high |
| mie_o | output | 1 | Machine interrupt enable |
| sie_o | output | 1 | Supervisor interrupt enable |
| mpie_o | output | 1 | Machine saved enable |
| spie_o | output | 1 | Supervisor saved enable |
| mpp_o | output | 2 | Saved machine previous privilege |
| spp_o | output | 1 | Saved supervisor previous privilege |
| mcause_o | output | XLEN | Machine cause |
| mepc_o | output | XLEN | Machine exception pc |
| mtval_o | output | XLEN | Machine trap value |
| scause_o | output | XLEN | Supervisor cause |
| sepc_o | output | XLEN | Supervisor exception pc |
| stval_o | output | XLEN | Supervisor trap value |

## Verification
Environment-call renumbering and delegation land in the same cycle. Routing must use the renumbered code, not the raw one. The sweep provokes this with an exception mask that has bit 9 set and bit 8 clear, and with a second mask that has only bit 8 set. A correct design sends a supervisor-mode call to supervisor level under the first mask and to machine level under the second, while a user-mode call does the reverse. Each such case is judged on the privilege, the cause value and the level whose registers moved. The vectored offset and the routing choice also meet in one cycle, because the selected vector decides whether the offset applies. Masks are paired with vectors of differing modes so that a wrong level choice shows up in `redirect_pc`.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_t;

    // Environment-call codes per originating level
    localparam int unsigned ECALL_FROM_U = 8;
    localparam int unsigned ECALL_FROM_S = 9;
    localparam int unsigned ECALL_FROM_M = 11;

    // Vector mode that enables the per-interrupt offset
    localparam logic [1:0] TVEC_VECTORED = 2'b01;

    // Widest code the helper function accepts
    localparam int unsigned CODE_MAX_W = 16;

    typedef struct packed {
        logic to_super;
        logic is_irq;
        logic keep_tval;
    } route_t;

    // Exception codes that carry an address in tval
    function automatic logic addr_bearing(input logic [CODE_MAX_W-1:0] c);
        logic r;
        case (c)
            16'd0, 16'd1,                 // fetch misaligned / fetch access
            16'd4, 16'd5,                 // load misaligned / load access
            16'd6, 16'd7,                 // store misaligned / store access
            16'd12, 16'd13, 16'd15:       // page faults
                r = 1'b1;
            default:
                r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/trap_route.sv
module trap_route
    import trap_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = 6
) (
    input  logic              is_irq,
    input  logic [CODE_W-1:0] raw_code,
    input  logic [1:0]        cur_priv,
    input  logic [XLEN-1:0]   exc_deleg,
    input  logic [XLEN-1:0]   irq_deleg,
    output logic [CODE_W-1:0] eff_code,
    output route_t            route
);

    logic [XLEN-1:0] sel_mask;
    logic [XLEN-1:0] shifted;
    logic            in_range;
    logic            low_priv;

    always_comb begin
        eff_code = raw_code;
        if (!is_irq && raw_code == CODE_W'(ECALL_FROM_U)) begin
            case (cur_priv)
                PRIV_U:  eff_code = CODE_W'(ECALL_FROM_U);
                PRIV_S:  eff_code = CODE_W'(ECALL_FROM_S);
                default: eff_code = CODE_W'(ECALL_FROM_M);
            endcase
        end
    end

    always_comb begin
        sel_mask = is_irq ? irq_deleg : exc_deleg;
        shifted  = sel_mask >> eff_code;
        in_range = 32'(eff_code) < 32'(XLEN);
        low_priv = (cur_priv == PRIV_U) || (cur_priv == PRIV_S);

        route.to_super  = low_priv && in_range && shifted[0];
        route.is_irq    = is_irq;
        route.keep_tval = !is_irq && addr_bearing(CODE_MAX_W'(eff_code));
    end

endmodule

// File: rtl/trap_vector.sv
module trap_vector
    import trap_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = 6
) (
    input  logic [XLEN-1:0]   tvec,
    input  logic              is_irq,
    input  logic [CODE_W-1:0] code,
    output logic [XLEN-1:0]   target
);

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    always_comb begin
        base   = {tvec[XLEN-1:2], 2'b00};
        offset = '0;
        if (is_irq && tvec[1:0] == TVEC_VECTORED)
            offset = XLEN'(code) << 2;
        target = base + offset;
    end

endmodule

// File: rtl/trap_csr_bank.sv
module trap_csr_bank #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              is_irq,
    input  logic [CODE_W-1:0] code,
    input  logic              keep_tval,
    input  logic [XLEN-1:0]   epc_in,
    input  logic [XLEN-1:0]   addr_in,
    output logic [XLEN-1:0]   cause_q,
    output logic [XLEN-1:0]   epc_q,
    output logic [XLEN-1:0]   tval_q
);

    localparam int PAD_W = XLEN - 1 - CODE_W;

    logic [XLEN-1:0] cause_d;

    always_comb begin
        cause_d = {is_irq, {PAD_W{1'b0}}, code};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
            epc_q   <= '0;
            tval_q  <= '0;
        end else if (wr) begin
            cause_q <= cause_d;
            epc_q   <= epc_in;
            tval_q  <= keep_tval ? addr_in : '0;
        end
    end

endmodule

// File: rtl/trap_status.sv
module trap_status
    import trap_pkg::*;
#(
    parameter logic MIE_RST = 1'b1,
    parameter logic SIE_RST = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       take,
    input  logic       to_super,
    input  logic [1:0] cur_priv,
    output logic [1:0] priv_q,
    output logic       mie_q,
    output logic       sie_q,
    output logic       mpie_q,
    output logic       spie_q,
    output logic [1:0] mpp_q,
    output logic       spp_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            priv_q <= PRIV_M;
            mie_q  <= MIE_RST;
            sie_q  <= SIE_RST;
            mpie_q <= 1'b0;
            spie_q <= 1'b0;
            mpp_q  <= PRIV_U;
            spp_q  <= 1'b0;
        end else if (take) begin
            if (to_super) begin
                spie_q <= sie_q;
                sie_q  <= 1'b0;
                spp_q  <= (cur_priv == PRIV_S);
                priv_q <= PRIV_S;
            end else begin
                mpie_q <= mie_q;
                mie_q  <= 1'b0;
                mpp_q  <= cur_priv;
                priv_q <= PRIV_M;
            end
        end
    end

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
    import trap_pkg::*;
#(
    parameter int   XLEN    = 32,
    parameter int   CODE_W  = 6,
    parameter logic MIE_RST = 1'b1,
    parameter logic SIE_RST = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trap_req,
    input  logic              trap_is_irq,
    input  logic [CODE_W-1:0] trap_code,
    input  logic [XLEN-1:0]   fault_addr,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [1:0]        cur_priv,
    input  logic [XLEN-1:0]   exc_deleg,
    input  logic [XLEN-1:0]   irq_deleg,
    input  logic [XLEN-1:0]   m_tvec,
    input  logic [XLEN-1:0]   s_tvec,
    output logic [1:0]        priv_o,
    output logic [XLEN-1:0]   redirect_pc,
    output logic              mie_o,
    output logic              sie_o,
    output logic              mpie_o,
    output logic              spie_o,
    output logic [1:0]        mpp_o,
    output logic              spp_o,
    output logic [XLEN-1:0]   mcause_o,
    output logic [XLEN-1:0]   mepc_o,
    output logic [XLEN-1:0]   mtval_o,
    output logic [XLEN-1:0]   scause_o,
    output logic [XLEN-1:0]   sepc_o,
    output logic [XLEN-1:0]   stval_o
);

    localparam int N_LEVELS = 2;   // index 0 = machine, 1 = supervisor

    route_t            route;
    logic [CODE_W-1:0] eff_code;
    logic [XLEN-1:0]   sel_tvec;

    logic [XLEN-1:0] cause_arr [N_LEVELS];
    logic [XLEN-1:0] epc_arr   [N_LEVELS];
    logic [XLEN-1:0] tval_arr  [N_LEVELS];

    trap_route #(.XLEN(XLEN), .CODE_W(CODE_W)) u_route (
        .is_irq    (trap_is_irq),
        .raw_code  (trap_code),
        .cur_priv  (cur_priv),
        .exc_deleg (exc_deleg),
        .irq_deleg (irq_deleg),
        .eff_code  (eff_code),
        .route     (route)
    );

    always_comb begin
        sel_tvec = route.to_super ? s_tvec : m_tvec;
    end

    trap_vector #(.XLEN(XLEN), .CODE_W(CODE_W)) u_vector (
        .tvec   (sel_tvec),
        .is_irq (route.is_irq),
        .code   (eff_code),
        .target (redirect_pc)
    );

    trap_status #(.MIE_RST(MIE_RST), .SIE_RST(SIE_RST)) u_status (
        .clk      (clk),
        .rst      (rst),
        .take     (trap_req),
        .to_super (route.to_super),
        .cur_priv (cur_priv),
        .priv_q   (priv_o),
        .mie_q    (mie_o),
        .sie_q    (sie_o),
        .mpie_q   (mpie_o),
        .spie_q   (spie_o),
        .mpp_q    (mpp_o),
        .spp_q    (spp_o)
    );

    for (genvar lvl = 0; lvl < N_LEVELS; lvl++) begin : g_bank
        logic wr_lvl;
        assign wr_lvl = trap_req && (route.to_super == (lvl == 1));

        trap_csr_bank #(.XLEN(XLEN), .CODE_W(CODE_W)) u_bank (
            .clk       (clk),
            .rst       (rst),
            .wr        (wr_lvl),
            .is_irq    (route.is_irq),
            .code      (eff_code),
            .keep_tval (route.keep_tval),
            .epc_in    (cur_pc),
            .addr_in   (fault_addr),
            .cause_q   (cause_arr[lvl]),
            .epc_q     (epc_arr[lvl]),
            .tval_q    (tval_arr[lvl])
        );
    end

    assign mcause_o = cause_arr[0];
    assign mepc_o   = epc_arr[0];
    assign mtval_o  = tval_arr[0];
    assign scause_o = cause_arr[1];
    assign sepc_o   = epc_arr[1];
    assign stval_o  = tval_arr[1];

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            trap_req,
    input logic            trap_is_irq,
    input logic [XLEN-1:0] cur_pc,
    input logic [1:0]      cur_priv,
    input logic [1:0]      priv_o,
    input logic [XLEN-1:0] redirect_pc,
    input logic            mie_o,
    input logic            sie_o,
    input logic            mpie_o,
    input logic            spie_o,
    input logic [XLEN-1:0] mcause_o,
    input logic [XLEN-1:0] mepc_o,
    input logic [XLEN-1:0] mtval_o,
    input logic [XLEN-1:0] scause_o,
    input logic [XLEN-1:0] sepc_o,
    input logic [XLEN-1:0] stval_o
);

    // R9
    level_after_entry_chk: assert property (@(posedge clk) disable iff (rst)
        trap_req |=> (priv_o == 2'd1 || priv_o == 2'd3));

    // R2
    no_delegation_from_high_chk: assert property (@(posedge clk) disable iff (rst)
        (trap_req && cur_priv[1]) |=> priv_o == 2'd3);

    // R3
    super_status_chk: assert property (@(posedge clk) disable iff (rst)
        trap_req |=> (priv_o != 2'd1) || (!sie_o && spie_o == $past(sie_o)));

    // R4
    machine_status_chk: assert property (@(posedge clk) disable iff (rst)
        trap_req |=> (priv_o != 2'd3) || (!mie_o && mpie_o == $past(mie_o)));

    // R5
    epc_capture_chk: assert property (@(posedge clk) disable iff (rst)
        trap_req |=> (priv_o == 2'd3) ? (mepc_o == $past(cur_pc)) : (sepc_o == $past(cur_pc)));

    // R5
    cause_flag_chk: assert property (@(posedge clk) disable iff (rst)
        trap_req |=> (priv_o == 2'd3) ? (mcause_o[XLEN-1] == $past(trap_is_irq))
                                      : (scause_o[XLEN-1] == $past(trap_is_irq)));

    // R6
    irq_tval_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (trap_req && trap_is_irq) |=> (priv_o == 2'd3) ? (mtval_o == '0) : (stval_o == '0));

    // R8
    pc_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> redirect_pc[1:0] == 2'b00);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !trap_req |=> $stable(priv_o) && $stable(mcause_o) && $stable(scause_o) &&
                      $stable(mepc_o) && $stable(sepc_o) && $stable(mtval_o) &&
                      $stable(stval_o) && $stable(mie_o) && $stable(sie_o));

endmodule

bind trap_entry_ctrl trap_entry_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .trap_req    (trap_req),
    .trap_is_irq (trap_is_irq),
    .cur_pc      (cur_pc),
    .cur_priv    (cur_priv),
    .priv_o      (priv_o),
    .redirect_pc (redirect_pc),
    .mie_o       (mie_o),
    .sie_o       (sie_o),
    .mpie_o      (mpie_o),
    .spie_o      (spie_o),
    .mcause_o    (mcause_o),
    .mepc_o      (mepc_o),
    .mtval_o     (mtval_o),
    .scause_o    (scause_o),
    .sepc_o      (sepc_o),
    .stval_o     (stval_o)
);

// File: tb/trap_entry_ctrl_tb.sv
`timescale 1ns/1ps
module trap_entry_ctrl_tb;

    localparam int XLEN   = 32;
    localparam int CODE_W = 6;

    logic              clk = 1'b0;
    logic              rst;
    logic              trap_req;
    logic              trap_is_irq;
    logic [CODE_W-1:0] trap_code;
    logic [XLEN-1:0]   fault_addr, cur_pc, exc_deleg, irq_deleg, m_tvec, s_tvec;
    logic [1:0]        cur_priv;
    logic [1:0]        priv_o, mpp_o;
    logic [XLEN-1:0]   redirect_pc;
    logic              mie_o, sie_o, mpie_o, spie_o, spp_o;
    logic [XLEN-1:0]   mcause_o, mepc_o, mtval_o, scause_o, sepc_o, stval_o;

    always #2 clk = ~clk;

    trap_entry_ctrl u_dut (
        .clk(clk), .rst(rst), .trap_req(trap_req), .trap_is_irq(trap_is_irq),
        .trap_code(trap_code), .fault_addr(fault_addr), .cur_pc(cur_pc),
        .cur_priv(cur_priv), .exc_deleg(exc_deleg), .irq_deleg(irq_deleg),
        .m_tvec(m_tvec), .s_tvec(s_tvec), .priv_o(priv_o), .redirect_pc(redirect_pc),
        .mie_o(mie_o), .sie_o(sie_o), .mpie_o(mpie_o), .spie_o(spie_o),
        .mpp_o(mpp_o), .spp_o(spp_o), .mcause_o(mcause_o), .mepc_o(mepc_o),
        .mtval_o(mtval_o), .scause_o(scause_o), .sepc_o(sepc_o), .stval_o(stval_o)
    );

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    // bench model of the architectural state
    logic [1:0]      e_priv, e_mpp;
    logic            e_mie, e_sie, e_mpie, e_spie, e_spp;
    logic [XLEN-1:0] e_mcause, e_mepc, e_mtval, e_scause, e_sepc, e_stval;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic cmp_all(input string ctx);
        chk({ctx, " R2 R9 priv"}, 32'(priv_o), 32'(e_priv));
        chk({ctx, " R4 mie"},     32'(mie_o),  32'(e_mie));
        chk({ctx, " R3 sie"},     32'(sie_o),  32'(e_sie));
        chk({ctx, " R4 mpie"},    32'(mpie_o), 32'(e_mpie));
        chk({ctx, " R3 spie"},    32'(spie_o), 32'(e_spie));
        chk({ctx, " R4 mpp"},     32'(mpp_o),  32'(e_mpp));
        chk({ctx, " R3 spp"},     32'(spp_o),  32'(e_spp));
        chk({ctx, " R5 mcause"},  mcause_o, e_mcause);
        chk({ctx, " R5 mepc"},    mepc_o,   e_mepc);
        chk({ctx, " R6 mtval"},   mtval_o,  e_mtval);
        chk({ctx, " R5 scause"},  scause_o, e_scause);
        chk({ctx, " R5 sepc"},    sepc_o,   e_sepc);
        chk({ctx, " R6 stval"},   stval_o,  e_stval);
    endtask

    // Drive one request at a falling edge; optionally follow with an idle cycle.
    task automatic apply(input logic [1:0] pv, input logic irq, input int code,
                         input logic [31:0] med, input logic [31:0] mid,
                         input logic [31:0] mtv, input logic [31:0] stv,
                         input logic [31:0] addr, input logic [31:0] pc,
                         input bit idle, input string ctx);
        int          ce;
        logic [31:0] msk, tv, exp_pc, cv;
        bit          tos, av, is_ecall;
        trap_req = 1'b1; trap_is_irq = irq; trap_code = CODE_W'(code);
        cur_priv = pv; exc_deleg = med; irq_deleg = mid;
        m_tvec = mtv; s_tvec = stv; fault_addr = addr; cur_pc = pc;

        is_ecall = !irq && code == 8;
        ce = code;
        if (is_ecall) ce = (pv == 2'd0) ? 8 : (pv == 2'd1) ? 9 : 11;
        msk = irq ? mid : med;
        tos = (pv <= 2'd1) && (ce < XLEN) && (((msk >> ce) & 32'd1) == 32'd1);
        av  = !irq && (ce inside {0, 1, 4, 5, 6, 7, 12, 13, 15});
        tv  = tos ? stv : mtv;
        exp_pc = tv & ~32'd3;
        if (irq && tv[1:0] == 2'b01) exp_pc = exp_pc + 32'(ce) * 32'd4;
        cv = (32'(irq) << 31) | 32'(ce);

        #1;
        chk(is_ecall ? {ctx, " R7 R8 pc"} : {ctx, " R8 pc"}, redirect_pc, exp_pc);

        if (tos) begin
            e_spie = e_sie; e_sie = 1'b0; e_spp = (pv == 2'd1);
            e_scause = cv; e_sepc = pc; e_stval = av ? addr : 32'd0;
            e_priv = 2'd1;
        end else begin
            e_mpie = e_mie; e_mie = 1'b0; e_mpp = pv;
            e_mcause = cv; e_mepc = pc; e_mtval = av ? addr : 32'd0;
            e_priv = 2'd3;
        end

        @(negedge clk);
        #1;
        if (is_ecall) chk({ctx, " R7 cause"}, tos ? scause_o : mcause_o, cv);
        cmp_all({ctx, " R11"});
        if (idle) begin
            trap_req = 1'b0; trap_is_irq = ~irq; trap_code = ~CODE_W'(code);
            cur_priv = ~pv; cur_pc = ~pc; fault_addr = ~addr;
            exc_deleg = ~med; irq_deleg = ~mid;
            @(negedge clk);
            #1;
            cmp_all({ctx, " R10"});
        end
        #0;
        @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    logic [31:0] p_med [4];
    logic [31:0] p_mid [4];
    logic [31:0] p_mtv [4];
    logic [31:0] p_stv [4];

    initial begin
        p_med[0] = 32'hFFFF_FFFF; p_mid[0] = 32'hFFFF_FFFF; p_mtv[0] = 32'h8000_0101; p_stv[0] = 32'h4000_0201;
        p_med[1] = 32'h0000_0000; p_mid[1] = 32'h0000_0000; p_mtv[1] = 32'h8000_0100; p_stv[1] = 32'h4000_0202;
        p_med[2] = 32'h0000_A2F3; p_mid[2] = 32'h0000_0222; p_mtv[2] = 32'h8000_0103; p_stv[2] = 32'h4000_0301;
        p_med[3] = 32'h0000_0100; p_mid[3] = 32'h5555_5555; p_mtv[3] = 32'h8000_0401; p_stv[3] = 32'h4000_0400;

        rst = 1'b1; trap_req = 1'b0; trap_is_irq = 1'b0; trap_code = '0;
        fault_addr = '0; cur_pc = '0; cur_priv = 2'd0;
        exc_deleg = '0; irq_deleg = '0; m_tvec = '0; s_tvec = '0;

        e_priv = 2'd3; e_mie = 1'b1; e_sie = 1'b1; e_mpie = 1'b0; e_spie = 1'b0;
        e_mpp = 2'd0; e_spp = 1'b0;
        e_mcause = '0; e_mepc = '0; e_mtval = '0; e_scause = '0; e_sepc = '0; e_stval = '0;

        repeat (3) @(negedge clk);
        #1;
        cmp_all("R1 in-reset");
        rst = 1'b0;
        @(negedge clk);
        #1;
        cmp_all("R1 after-reset");
        @(negedge clk);

        // full sweep: masks/vectors x privilege x kind x code
        for (int p = 0; p < 4; p++)
            for (int pv = 0; pv < 4; pv++)
                for (int irq = 0; irq < 2; irq++)
                    for (int c = 0; c < 64; c++)
                        apply(2'(pv), 1'(irq), c, p_med[p], p_mid[p], p_mtv[p], p_stv[p],
                              32'hA000_0000 + 32'(c * 16 + pv),
                              32'h0001_0000 + 32'(p * 4096 + c * 4), 1'b1, "sweep");

        // back-to-back requests with no idle cycle between them
        for (int k = 0; k < 32; k++)
            apply(2'(k % 4), 1'(k % 3 == 0), (k * 7) % 20, p_med[2], p_mid[2],
                  p_mtv[(k / 4) % 4], p_stv[(k / 8) % 4],
                  32'hC000_0000 + 32'(k), 32'h0002_0000 + 32'(k * 4), 1'b0, "b2b");

        // reset again returns to the reset state
        rst = 1'b1;
        e_priv = 2'd3; e_mie = 1'b1; e_sie = 1'b1; e_mpie = 1'b0; e_spie = 1'b0;
        e_mpp = 2'd0; e_spp = 1'b0;
        e_mcause = '0; e_mepc = '0; e_mtval = '0; e_scause = '0; e_sepc = '0; e_stval = '0;
        @(negedge clk);
        #1;
        cmp_all("R1 re-reset");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule